// File: doc/BRIEF.md
# Prioritised UART Interrupt Identifier

This block gathers the four interrupt causes of an asynchronous serial port into one interrupt line and an identification byte that the host reads to learn which cause to service first. The causes are receive line errors, arrival of a received byte, the transmit holding register going empty, and a change on the modem control inputs. Each cause has its own sticky pending flag. The flag is set by an event the block sees, and it is cleared only by the host access that belongs to that cause.

The enable bits gate what the host sees: a pending flag with its enable bit low neither raises the interrupt line nor appears in the identification byte. The flag itself stays set, so setting the enable bit again brings the cause back at once. The surrounding register decode gives the block one-cycle access pulses and the current enable value. The serial datapath gives it error pulses and status levels.

Encoding used throughout: enable and cause index 3 is line status, 2 is received data, 1 is transmit empty and 0 is modem status. That index is also the 2-bit code placed in bits 2:1 of the identification byte.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, and whenever no enabled cause is pending, `id_o` reads 01h and `irq_o` is low. Bits 7:3 of `id_o` are always 0, and bit 0 is 0 exactly when an enabled cause is pending.
- R2: `irq_o` is high exactly when at least one cause is both pending and enabled.
- R3: When several enabled causes are pending, the highest one is reported. The values are 06h for line status, 04h for received data, 02h for transmit empty and 00h for modem status, in that order of priority.
- R4: A pulse on any bit of `ls_flags_i` sets line-status pending. The bits are parity, framing, overrun and break, from bit 0 to bit 3. A `rd_lsr_i` pulse clears it.
- R5: An `rx_avail_i` pulse sets received-data pending, and a `rd_rbr_i` pulse clears it.
- R6: Transmit-empty pending is set on a 0-to-1 transition of `thr_empty_i`. It is also set by an `en_wr_i` pulse while `en_i[1]` is 1 and `thr_empty_i` is 1. A `wr_thr_i` pulse clears it. An `en_wr_i` pulse while `thr_empty_i` is 0 does not set it.
- R7: A `rd_iir_i` pulse clears transmit-empty pending only in a cycle where `id_o` reads 02h. At any other time it leaves the flag untouched.
- R8: Modem pending is set by either transition of any `modem_lines_i` bit (bit 0 clear-to-send, bit 1 data-set-ready, bit 2 carrier detect) and by a 1-to-0 transition of `ring_i`. A 0-to-1 transition of `ring_i` does not set it. A `rd_msr_i` pulse clears it.
- R9: Clearing an enable bit hides its cause in the same cycle without discarding the pending flag. Setting the bit again reports the cause again.
- R10: When a set event and its clearing access fall in the same cycle, the cause ends up pending.
- R11: Inputs take effect at the next rising clock edge. Edges on level inputs are judged against the value sampled at the previous edge, and no edge is seen in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 4 | Enable bits by cause index (3 line, 2 data, 1 tx, 0 modem) |
| en_wr_i | input | 1 | Pulse: enable register written, `en_i` holds the new value |
| ls_flags_i | input | LS_W | Line error pulses: parity, framing, overrun, break |
| rx_avail_i | input | 1 | Pulse: a received byte became available |
| thr_empty_i | input | 1 | Level: transmit holding register empty |
| modem_lines_i | input | MODEM_W | Levels: clear-to-send, data-set-ready, carrier detect |
| ring_i | input | 1 | Level: ring indicator |
| rd_lsr_i | input | 1 | Pulse: host read of line status |
| rd_rbr_i | input | 1 | Pulse: host read of received data |
| wr_thr_i | input | 1 | Pulse: host write of transmit holding register |
| rd_iir_i | input | 1 | Pulse: host read of identification byte |
| rd_msr_i | input | 1 | Pulse: host read of modem status |
| id_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A table of enable masks crossed with sets of pending causes drives the priority encoder. All four causes under full enable show the fixed order. Single and paired causes show each code on its own. Partial masks show that a disabled higher cause gives way to a lower enabled one and is not reported. Directed sequences then separate the clearing rules: an identification read taken while the line-status code is shown leaves transmit-empty pending, and the next read clears it. Ring edges in both directions show that only the falling one counts. A clear taken together with a set shows that the set wins.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ID_W = 2;
  localparam int NSRC = 1 << ID_W;
  localparam int IX_MODEM = 0;
  localparam int IX_TX    = 1;
  localparam int IX_RXD   = 2;
  localparam int IX_LINE  = 3;

  // highest set index among active causes
  function automatic logic [ID_W-1:0] top_index(input logic [NSRC-1:0] act);
    logic [ID_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (act[i]) idx = ID_W'(i);
    end
    return idx;
  endfunction

  // identification byte: code in bits 2:1, bit 0 low when pending
  function automatic logic [7:0] id_byte(input logic any, input logic [ID_W-1:0] idx);
    return {{(7-ID_W){1'b0}}, (any ? idx : {ID_W{1'b0}}), ~any};
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 1,
  parameter logic [W-1:0] RISE_MASK = '1,
  parameter logic [W-1:0] FALL_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] prev_q;
  logic         armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= d_i;
      armed_q <= 1'b1;
    end
  end

  assign edge_o = armed_q ? (((d_i & ~prev_q) & RISE_MASK) | ((~d_i & prev_q) & FALL_MASK))
                          : '0;
endmodule

// File: rtl/irq_pend_cell.sv
module irq_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= set_i | (pend_o & ~clr_i);
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] act_i,
  output logic [7:0]      id_o,
  output logic            any_o,
  output logic            tx_shown_o
);
  logic [ID_W-1:0] idx;

  assign any_o      = |act_i;
  assign idx        = top_index(act_i);
  assign id_o       = id_byte(any_o, idx);
  assign tx_shown_o = any_o && (idx == ID_W'(IX_TX));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int LS_W    = 4,
  parameter int MODEM_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    en_i,
  input  logic               en_wr_i,
  input  logic [LS_W-1:0]    ls_flags_i,
  input  logic               rx_avail_i,
  input  logic               thr_empty_i,
  input  logic [MODEM_W-1:0] modem_lines_i,
  input  logic               ring_i,
  input  logic               rd_lsr_i,
  input  logic               rd_rbr_i,
  input  logic               wr_thr_i,
  input  logic               rd_iir_i,
  input  logic               rd_msr_i,
  output logic [7:0]         id_o,
  output logic               irq_o
);
  // watched levels packed as {ring, modem lines, thr_empty}
  localparam int EW = MODEM_W + 2;
  localparam logic [EW-1:0] RISE_M = {1'b0, {MODEM_W{1'b1}}, 1'b1};
  localparam logic [EW-1:0] FALL_M = {1'b1, {MODEM_W{1'b1}}, 1'b0};

  logic [EW-1:0]   edge_w;
  logic            thr_rise_w;
  logic            modem_evt_w;
  logic            tx_shown_w;
  logic            any_w;
  logic [NSRC-1:0] set_w;
  logic [NSRC-1:0] clr_w;
  logic [NSRC-1:0] pend_w;
  logic [NSRC-1:0] act_w;

  irq_edge_det #(.W(EW), .RISE_MASK(RISE_M), .FALL_MASK(FALL_M)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    ({ring_i, modem_lines_i, thr_empty_i}),
    .edge_o (edge_w)
  );

  assign thr_rise_w  = edge_w[0];
  assign modem_evt_w = |edge_w[EW-1:1];

  always_comb begin
    set_w           = '0;
    set_w[IX_LINE]  = |ls_flags_i;
    set_w[IX_RXD]   = rx_avail_i;
    set_w[IX_TX]    = thr_rise_w | (en_wr_i & en_i[IX_TX] & thr_empty_i);
    set_w[IX_MODEM] = modem_evt_w;
    clr_w           = '0;
    clr_w[IX_LINE]  = rd_lsr_i;
    clr_w[IX_RXD]   = rd_rbr_i;
    clr_w[IX_TX]    = wr_thr_i | (rd_iir_i & tx_shown_w);
    clr_w[IX_MODEM] = rd_msr_i;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_cause
    irq_pend_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_w[g]),
      .clr_i  (clr_w[g]),
      .pend_o (pend_w[g])
    );
  end

  assign act_w = pend_w & en_i;

  irq_prio_enc u_enc (
    .act_i      (act_w),
    .id_o       (id_o),
    .any_o      (any_w),
    .tx_shown_o (tx_shown_w)
  );

  assign irq_o = any_w;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] en_i,
  input logic [7:0] id_o,
  input logic       irq_o,
  input logic [3:0] pend_w,
  input logic [3:0] set_w,
  input logic [3:0] clr_w
);
  AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    id_o[7:3] == 5'd0); // R1

  AST_IRQ_VS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == !id_o[0]); // R2

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_w & en_i) == 4'd0) |-> !irq_o); // R9

  AST_LINE_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_w[3] && en_i[3]) |-> (id_o == 8'h06)); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_w) |=> ((pend_w & $past(set_w)) == $past(set_w))); // R10

  AST_DATA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w[2] && !set_w[2]) |=> !pend_w[2]); // R5
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en_i   (en_i),
  .id_o   (id_o),
  .irq_o  (irq_o),
  .pend_w (pend_w),
  .set_w  (set_w),
  .clr_w  (clr_w)
);

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] en_i;
  logic       en_wr_i;
  logic [3:0] ls_flags_i;
  logic       rx_avail_i;
  logic       thr_empty_i;
  logic [2:0] modem_lines_i;
  logic       ring_i;
  logic       rd_lsr_i, rd_rbr_i, wr_thr_i, rd_iir_i, rd_msr_i;
  logic [7:0] id_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .en_wr_i(en_wr_i),
    .ls_flags_i(ls_flags_i), .rx_avail_i(rx_avail_i), .thr_empty_i(thr_empty_i),
    .modem_lines_i(modem_lines_i), .ring_i(ring_i),
    .rd_lsr_i(rd_lsr_i), .rd_rbr_i(rd_rbr_i), .wr_thr_i(wr_thr_i),
    .rd_iir_i(rd_iir_i), .rd_msr_i(rd_msr_i), .id_o(id_o), .irq_o(irq_o)
  );

  // {enable[3:0], causes[3:0], expected id}; index 3 line, 2 data, 1 tx, 0 modem
  localparam logic [15:0] VEC [9] = '{
    16'hFF_06, 16'hF7_04, 16'hF3_02, 16'hF1_00, 16'h0F_01,
    16'h7F_04, 16'h96_01, 16'h5F_04, 16'h23_02
  };

  task automatic chk(input string req, input logic [7:0] exp_id);
    checks++;
    if (id_o !== exp_id || irq_o !== ~exp_id[0]) begin
      errors++;
      $display("FAIL %s: id=%02h irq=%0b expected id=%02h irq=%0b",
               req, id_o, irq_o, exp_id, ~exp_id[0]);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_all();
    rd_lsr_i = 1'b1; rd_rbr_i = 1'b1; wr_thr_i = 1'b1; rd_msr_i = 1'b1;
    step();
    rd_lsr_i = 1'b0; rd_rbr_i = 1'b0; wr_thr_i = 1'b0; rd_msr_i = 1'b0;
  endtask

  task automatic raise(input logic [3:0] src);
    if (src[1]) begin
      thr_empty_i = 1'b0;
      step();
      thr_empty_i = 1'b1;
    end
    ls_flags_i = src[3] ? 4'b0001 : 4'b0000;
    rx_avail_i = src[2];
    if (src[0]) modem_lines_i[0] = ~modem_lines_i[0];
    step();
    ls_flags_i = '0;
    rx_avail_i = 1'b0;
  endtask

  task automatic pulse_iir();
    rd_iir_i = 1'b1; step(); rd_iir_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; en_i = '0; en_wr_i = 1'b0; ls_flags_i = '0; rx_avail_i = 1'b0;
    thr_empty_i = 1'b1; modem_lines_i = '0; ring_i = 1'b0;
    rd_lsr_i = 1'b0; rd_rbr_i = 1'b0; wr_thr_i = 1'b0; rd_iir_i = 1'b0; rd_msr_i = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step(); step();
    chk("R1 reset idle", 8'h01);
    en_i = 4'hF;
    chk("R1 enabled but nothing pending", 8'h01);
    // R11: an edge present at the first sampled cycle is judged against the previous sample
    thr_empty_i = 1'b1;

    // priority table across masks (R2, R3, R9)
    for (int i = 0; i < 9; i++) begin
      en_i = VEC[i][15:12];
      clear_all();
      raise(VEC[i][11:8]);
      chk("R3/R2 table", VEC[i][7:0]);
    end
    en_i = 4'hF;
    clear_all();

    // R4: break bit alone, then cleared by line status read
    ls_flags_i = 4'b1000; step(); ls_flags_i = '0;
    chk("R4 break sets line status", 8'h06);
    rd_lsr_i = 1'b1; step(); rd_lsr_i = 1'b0;
    chk("R4 line status read clears", 8'h01);

    // R5
    rx_avail_i = 1'b1; step(); rx_avail_i = 1'b0;
    chk("R5 data sets", 8'h04);
    rd_rbr_i = 1'b1; step(); rd_rbr_i = 1'b0;
    chk("R5 data read clears", 8'h01);

    // R7: id read while line status shown keeps tx pending
    raise(4'b1010);
    chk("R7 line over tx", 8'h06);
    pulse_iir();
    chk("R7 id read with line shown", 8'h06);
    rd_lsr_i = 1'b1; step(); rd_lsr_i = 1'b0;
    chk("R7 tx survived id read", 8'h02);
    pulse_iir();
    chk("R7 id read showing tx clears", 8'h01);

    // R6: enable write with holding register empty
    en_wr_i = 1'b1; step(); en_wr_i = 1'b0;
    chk("R6 enable write sets tx", 8'h02);
    wr_thr_i = 1'b1; step(); wr_thr_i = 1'b0;
    chk("R6 holding write clears", 8'h01);
    thr_empty_i = 1'b0; step();
    en_wr_i = 1'b1; step(); en_wr_i = 1'b0;
    chk("R6 enable write while full", 8'h01);
    thr_empty_i = 1'b1; step();
    chk("R6 rising empty sets tx", 8'h02);
    clear_all();

    // R8: ring edges and line changes
    ring_i = 1'b1; step();
    chk("R8 ring rising ignored", 8'h01);
    ring_i = 1'b0; step();
    chk("R8 ring falling sets", 8'h00);
    rd_msr_i = 1'b1; step(); rd_msr_i = 1'b0;
    chk("R8 modem read clears", 8'h01);
    modem_lines_i[1] = 1'b1; step();
    chk("R8 dsr change sets", 8'h00);
    rd_msr_i = 1'b1; step(); rd_msr_i = 1'b0;
    modem_lines_i[2] = 1'b1; step();
    chk("R8 carrier change sets", 8'h00);
    rd_msr_i = 1'b1; step(); rd_msr_i = 1'b0;
    modem_lines_i[2] = 1'b0; step();
    chk("R8 carrier falling sets", 8'h00);
    rd_msr_i = 1'b1; step(); rd_msr_i = 1'b0;
    chk("R8 cleared again", 8'h01);

    // R9: mask keeps pending flag
    rx_avail_i = 1'b1; step(); rx_avail_i = 1'b0;
    en_i = 4'b1011;
    #1 chk("R9 masked data hidden", 8'h01);
    en_i = 4'hF;
    #1 chk("R9 unmasked data returns", 8'h04);
    clear_all();

    // R10: set and clear in one cycle
    rx_avail_i = 1'b1; rd_rbr_i = 1'b1; step();
    rx_avail_i = 1'b0; rd_rbr_i = 1'b0;
    chk("R10 set beats clear", 8'h04);
    clear_all();
    chk("R1 idle at end", 8'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule